// File: doc/BRIEF.md
# Run-Time Configurable Interrupt Router

This block sits between a set of 32 level-sensitive peripheral interrupt requests and a small number of CPU interrupt lines. Software picks, for each request line, which single CPU-side output it drives. A line can also be left unconnected. Each request line has its own enable bit. A read-only status word shows which enabled requests are active at the moment of the read.

Software reaches the block through a plain 32-bit register bus that uses separate write and read strobes. The read data is registered, and it returns zero in any cycle that follows no read. The output vector is registered. Its width is set by the parameter `N_OUT`, which may be 1 to 15. Priority, vectoring and edge capture are left to the CPU-side interrupt logic.

Top module: `irq_router`

## Requirements
- R1: After reset every enable bit and every routing field is zero, `irq_out` is all zero, and reads of the enable and routing words return zero.
- R2: The word at byte offset 0x00 holds the enable bits, with bit n enabling request n (1 = enabled). A write updates all 32 bits, and a later read returns the written value.
- R3: The word at offset 0x04 is read-only. A read returns `irq_in & enable`, sampled on the clock edge that takes the read. Writes to this offset change no state.
- R4: Routing uses a 4-bit field per request. Offsets 0x08, 0x0C, 0x10 and 0x14 hold requests 0-7, 8-15, 16-23 and 24-31. Request n occupies bits 4*(n%8)+3 : 4*(n%8) of its word. Writes store the fields, and reads return them.
- R5: A routing value of 0 connects the request to no output. A value k from 1 to `N_OUT` connects it to output k-1.
- R6: A routing value greater than `N_OUT` acts exactly like 0, so the request drives no output.
- R7: Output j is the OR of every request that is active, enabled and routed to j. A disabled request never drives any output.
- R8: A change on `irq_in`, or to the enable or routing state, reaches `irq_out` on the following rising clock edge. A register write therefore shows on `irq_out` one edge after the edge that stores it.
- R9: Offsets 0x18 and 0x1C read as zero, and writes to them change no state. Address bits 1:0 are ignored.
- R10: `rdata` is valid on the edge after `rd_en` is sampled high, and it is zero after any edge at which `rd_en` was low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe for one cycle |
| rd_en | input | 1 | Read strobe for one cycle |
| addr | input | 5 | Byte address of the register word |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| irq_in | input | 32 | Level-sensitive request lines from peripherals |
| irq_out | output | N_OUT | Registered interrupt lines toward the CPU |

## Verification
The routing function is driven with four kinds of pattern. A single enabled request is routed to each kind of field value: zero, an in-range value, the top value `N_OUT`, and values above it. This separates correct decoding from off-by-one and missing-range-check faults. Two requests share one output, which shows that the outputs OR together rather than one request overwriting another. An enable bit is cleared while its request stays active, which separates masking from routing. Last, several hundred cycles of mixed random writes, reads and request changes are compared clock by clock against a behavioural model, to catch faults in field placement, status sampling and latency.

// File: rtl/irq_rt_pkg.sv
package irq_rt_pkg;
    localparam int unsigned REG_W      = 32;
    localparam int unsigned FIELD_W    = 4;
    localparam int unsigned FIELDS_PW  = REG_W / FIELD_W;
    localparam int unsigned BUS_ADDR_W = 5;

    // word indices inside the register window
    localparam int WIX_ENABLE = 0;
    localparam int WIX_STATUS = 1;
    localparam int WIX_ROUTE0 = 2;
endpackage

// File: rtl/irq_rt_field_dec.sv
module irq_rt_field_dec #(
    parameter int FW    = 4,
    parameter int N_OUT = 15
) (
    input  logic [FW-1:0]    field,
    output logic [N_OUT-1:0] sel
);
    // value k selects output k-1; zero and values above N_OUT select nothing
    always_comb begin
        sel = '0;
        for (int j = 0; j < N_OUT; j++) begin
            if (field == FW'(j + 1)) begin
                sel[j] = 1'b1;
            end
        end
    end
endmodule

// File: rtl/irq_rt_regs.sv
module irq_rt_regs
    import irq_rt_pkg::*;
#(
    parameter int N_IN = 32
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic                    rd_en,
    input  logic [BUS_ADDR_W-1:0]   addr,
    input  logic [REG_W-1:0]        wdata,
    input  logic [N_IN-1:0]         irq_in,
    output logic [N_IN-1:0]         mask_q,
    output logic [N_IN*FIELD_W-1:0] route_q,
    output logic [REG_W-1:0]        rdata
);
    localparam int RT_WORDS = (N_IN + FIELDS_PW - 1) / FIELDS_PW;
    localparam int RT_LAST  = WIX_ROUTE0 + RT_WORDS - 1;

    logic [31:0]      wix;
    logic [REG_W-1:0] rd_word;
    logic [REG_W-1:0] rdata_q;
    logic             unused_lsbs;

    assign wix         = {{(34 - BUS_ADDR_W){1'b0}}, addr[BUS_ADDR_W-1:2]};
    assign unused_lsbs = ^addr[1:0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q <= '0;
        end else if (wr_en && wix == WIX_ENABLE) begin
            mask_q <= wdata[N_IN-1:0];
        end
    end

    for (genvar i = 0; i < N_IN; i++) begin : g_field
        localparam int WORD = WIX_ROUTE0 + i / FIELDS_PW;
        localparam int SLOT = i % FIELDS_PW;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                route_q[i*FIELD_W +: FIELD_W] <= '0;
            end else if (wr_en && wix == WORD) begin
                route_q[i*FIELD_W +: FIELD_W] <= wdata[SLOT*FIELD_W +: FIELD_W];
            end
        end
    end

    always_comb begin
        rd_word = '0;
        if (wix == WIX_ENABLE) begin
            rd_word[N_IN-1:0] = mask_q;
        end else if (wix == WIX_STATUS) begin
            rd_word[N_IN-1:0] = irq_in & mask_q;
        end else begin
            for (int i = 0; i < N_IN; i++) begin
                if (wix == WIX_ROUTE0 + i / FIELDS_PW) begin
                    rd_word[(i % FIELDS_PW)*FIELD_W +: FIELD_W] = route_q[i*FIELD_W +: FIELD_W];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else begin
            rdata_q <= rd_en ? rd_word : '0;
        end
    end

    assign rdata = rdata_q;

    // R2
    mask_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wix == WIX_ENABLE) |=> mask_q == $past(wdata[N_IN-1:0]));

    // R9
    ro_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wix == WIX_STATUS || wix > RT_LAST)) |=> ($stable(mask_q) && $stable(route_q)));

    // R10
    rd_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> rdata == '0);
endmodule

// File: rtl/irq_rt_steer.sv
module irq_rt_steer
    import irq_rt_pkg::*;
#(
    parameter int N_IN  = 32,
    parameter int N_OUT = 15
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [N_IN-1:0]         irq_in,
    input  logic [N_IN-1:0]         mask_q,
    input  logic [N_IN*FIELD_W-1:0] route_q,
    output logic [N_OUT-1:0]        irq_out
);
    logic [N_OUT-1:0] sel_v [N_IN];
    logic [N_OUT-1:0] out_d;
    logic [N_OUT-1:0] out_q;

    for (genvar i = 0; i < N_IN; i++) begin : g_dec
        irq_rt_field_dec #(.FW(FIELD_W), .N_OUT(N_OUT)) u_dec (
            .field (route_q[i*FIELD_W +: FIELD_W]),
            .sel   (sel_v[i])
        );
    end

    always_comb begin
        out_d = '0;
        for (int i = 0; i < N_IN; i++) begin
            if (irq_in[i] && mask_q[i]) begin
                out_d = out_d | sel_v[i];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign irq_out = out_q;

    // R7
    any_out_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|irq_out) |-> $past(|(irq_in & mask_q)));
endmodule

// File: rtl/irq_router.sv
module irq_router
    import irq_rt_pkg::*;
#(
    parameter int N_OUT = 5
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic                  rd_en,
    input  logic [BUS_ADDR_W-1:0] addr,
    input  logic [REG_W-1:0]      wdata,
    output logic [REG_W-1:0]      rdata,
    input  logic [31:0]           irq_in,
    output logic [N_OUT-1:0]      irq_out
);
    localparam int N_IN = 32;

    logic [N_IN-1:0]         mask_q;
    logic [N_IN*FIELD_W-1:0] route_q;

    irq_rt_regs #(.N_IN(N_IN)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .rd_en   (rd_en),
        .addr    (addr),
        .wdata   (wdata),
        .irq_in  (irq_in),
        .mask_q  (mask_q),
        .route_q (route_q),
        .rdata   (rdata)
    );

    irq_rt_steer #(.N_IN(N_IN), .N_OUT(N_OUT)) u_steer (
        .clk     (clk),
        .rst_n   (rst_n),
        .irq_in  (irq_in),
        .mask_q  (mask_q),
        .route_q (route_q),
        .irq_out (irq_out)
    );
endmodule

// File: tb/irq_router_tb_top.sv
module irq_router_tb_top;
    localparam int NO = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic          rd_en = 1'b0;
    logic [4:0]    addr = '0;
    logic [31:0]   wdata = '0;
    logic [31:0]   rdata;
    logic [31:0]   irq_in = '0;
    logic [NO-1:0] irq_out;

    int    n_checks = 0;
    int    n_errors = 0;
    int    cycles = 0;
    string cur_req = "R1";

    always #10 clk = ~clk;

    irq_router #(.N_OUT(NO)) dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .irq_in(irq_in), .irq_out(irq_out)
    );

    // behavioural reference model
    logic [31:0]   m_mask;
    logic [3:0]    m_rt [32];
    logic [NO-1:0] exp_out;
    logic [31:0]   exp_rd;

    function automatic logic [31:0] model_read(input logic [4:0] a);
        int w = int'(a) / 4;
        logic [31:0] r = 0;
        if (w == 0) r = m_mask;
        else if (w == 1) r = irq_in & m_mask;
        else if (w >= 2 && w <= 5)
            for (int f = 0; f < 8; f++) r[4*f +: 4] = m_rt[(w - 2) * 8 + f];
        return r;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_mask  <= 0;
            for (int i = 0; i < 32; i++) m_rt[i] <= 0;
            exp_out <= 0;
            exp_rd  <= 0;
        end else begin
            logic [NO-1:0] nx;
            int w;
            nx = 0;
            for (int j = 0; j < NO; j++)
                for (int i = 0; i < 32; i++)
                    if (m_mask[i] && irq_in[i] && int'(m_rt[i]) == j + 1) nx[j] = 1'b1;
            exp_out <= nx;
            exp_rd  <= rd_en ? model_read(addr) : 32'h0;
            if (wr_en) begin
                w = int'(addr) / 4;
                if (w == 0) m_mask <= wdata;
                else if (w >= 2 && w <= 5)
                    for (int f = 0; f < 8; f++) m_rt[(w - 2) * 8 + f] <= wdata[4*f +: 4];
            end
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    // clock-by-clock comparison against the model
    always @(negedge clk) begin
        cycles++;
        if (rst_n) begin
            chk({cur_req, " irq_out vs model"}, 32'(irq_out), 32'(exp_out));
            chk({cur_req, " rdata vs model"}, rdata, exp_rd);
        end
    end

    task automatic finish_run;
        $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
        $finish;
    endtask

    initial begin
        wait (cycles > 100000);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog expired actual %0d expected below 100000", cycles);
        finish_run();
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        d = rdata;
    endtask

    initial begin
        logic [31:0] v;
        step(3);
        rst_n = 1'b1;
        step(1);

        // R1 reset state
        cur_req = "R1";
        chk("R1 irq_out after reset", 32'(irq_out), 0);
        rd(5'h00, v); chk("R1 enable after reset", v, 0);
        rd(5'h08, v); chk("R1 route word 0 after reset", v, 0);
        rd(5'h14, v); chk("R1 route word 3 after reset", v, 0);

        // R2 enable register
        cur_req = "R2";
        wr(5'h00, 32'hA5A5_0F0F);
        rd(5'h00, v); chk("R2 enable readback", v, 32'hA5A5_0F0F);

        // R4 routing field layout
        cur_req = "R4";
        wr(5'h08, 32'h8765_4321);
        rd(5'h08, v); chk("R4 route word 0 readback", v, 32'h8765_4321);
        wr(5'h14, 32'hF000_000E);
        rd(5'h14, v); chk("R4 route word 3 readback", v, 32'hF000_000E);
        rd(5'h0C, v); chk("R4 route word 1 untouched", v, 0);
        wr(5'h08, 0); wr(5'h14, 0); wr(5'h00, 0);

        // R5 / R8 request 3 to field 2 -> output 1
        cur_req = "R5";
        wr(5'h08, 32'h0000_2000);
        wr(5'h00, 32'h0000_0008);
        irq_in = 32'h0000_0008;
        chk("R8 irq_out before edge", 32'(irq_out), 0);
        step(1);
        chk("R5 R8 field 2 drives output 1", 32'(irq_out), 32'h02);

        // R7 masking
        cur_req = "R7";
        wr(5'h00, 0);
        chk("R8 old enable still visible", 32'(irq_out), 32'h02);
        step(1);
        chk("R7 disabled request drives nothing", 32'(irq_out), 0);

        // R7 OR of two requests on one output
        wr(5'h14, 32'h0002_0000);
        wr(5'h00, 32'h1000_0008);
        irq_in = 32'h1000_0000;
        step(1);
        chk("R7 request 28 alone", 32'(irq_out), 32'h02);
        irq_in = 32'h1000_0008;
        step(1);
        chk("R7 both requests", 32'(irq_out), 32'h02);
        irq_in = 32'h0000_0008;
        step(1);
        chk("R7 request 3 alone", 32'(irq_out), 32'h02);

        // R5 / R6 field range
        cur_req = "R6";
        wr(5'h08, 32'h0000_5000); step(1);
        chk("R5 top field value selects last output", 32'(irq_out), 32'h10);
        wr(5'h08, 32'h0000_6000); step(1);
        chk("R6 field above N_OUT disconnected", 32'(irq_out), 0);
        wr(5'h08, 32'h0000_F000); step(1);
        chk("R6 field 15 disconnected", 32'(irq_out), 0);
        wr(5'h08, 32'h0000_0000); step(1);
        chk("R5 field 0 disconnected", 32'(irq_out), 0);
        wr(5'h08, 32'h0000_1000); step(1);
        chk("R5 field 1 selects output 0", 32'(irq_out), 32'h01);

        // R3 status
        cur_req = "R3";
        wr(5'h00, 32'h0000_0018);
        irq_in = 32'h0000_00F8;
        rd(5'h04, v); chk("R3 status is request and enable", v, 32'h18);
        wr(5'h04, 32'hFFFF_FFFF);
        rd(5'h00, v); chk("R3 status write leaves enable", v, 32'h18);
        rd(5'h04, v); chk("R3 status after write", v, 32'h18);

        // R9 unmapped offsets
        cur_req = "R9";
        rd(5'h18, v); chk("R9 offset 0x18 reads zero", v, 0);
        wr(5'h18, 32'hFFFF_FFFF);
        wr(5'h1C, 32'hFFFF_FFFF);
        rd(5'h1C, v); chk("R9 offset 0x1C reads zero", v, 0);
        rd(5'h00, v); chk("R9 unmapped write leaves enable", v, 32'h18);
        rd(5'h0B, v); chk("R9 low address bits ignored", v, 32'h0000_1000);

        // R10 idle read data
        cur_req = "R10";
        step(1);
        chk("R10 rdata zero without read", rdata, 0);

        // random mixed traffic compared against the model
        cur_req = "R7";
        for (int k = 0; k < 600; k++) begin
            @(negedge clk);
            wr_en  = ($urandom % 4) == 0;
            rd_en  = ($urandom % 3) == 0;
            addr   = 5'($urandom % 32);
            wdata  = $urandom;
            irq_in = $urandom;
        end
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0;
        step(2);
        finish_run();
    end
endmodule